// File: doc/BRIEF.md
# Prefix-Timed Far Data Window

This block lets a processor with a 16-bit address bus reach a 24-bit memory space, but only for the data cycle or cycles of a single instruction. Software places a one-byte prefix opcode in front of the instruction that needs far data. When the processor fetches that prefix, the block loads a short shift register with a marker pattern. The pattern moves one place per bus cycle. When the marker reaches the output, the block raises a far strobe and drives the eight upper address bits from an external far-bank value instead of the default zero bank.

The prefix code chooses how many bus cycles after the prefix the window opens, so it can match the data cycle of the target's address mode. One bit of the code stretches the window to three consecutive cycles, which covers a read-modify-write target. The window never covers an opcode fetch, so instruction fetches always use the normal mapping. The mapping is a one-shot. It is not a persistent bank setting.

Top module: `far_window`

## Requirements
- R1: While reset is applied, and after reset is released, the far strobe is low and the upper address is 8'h00, and a prefix that was pending when reset arrived never fires.
- R2: A prefix is recognised only in a cycle with `sync_i` high and `opcode_i[7:3]` equal to 5'b10110. Bits [1:0] give the delay D = 2 + bits[1:0], and bit [2] selects the long window. This gives prefix codes 8'hB0 to 8'hB7.
- R3: With bit [2] clear, if the prefix fetch is in bus cycle P, the far strobe is high in cycle P+1+D only, for exactly one cycle.
- R4: With bit [2] set, the far strobe is high in cycles P+1+D, P+2+D and P+3+D, which are three consecutive cycles.
- R5: When the far strobe is high, `upper_addr_o` equals `far_bank_i` in that same cycle. Otherwise `upper_addr_o` is 8'h00.
- R6: The far strobe is never high in a cycle with `sync_i` high. If an opcode fetch falls inside an open window, that cycle and the rest of the window are cancelled.
- R7: A prefix fetched while an earlier prefix is still pending replaces it. Only the timing of the newer prefix takes effect.
- R8: An opcode fetch that is not a prefix does not arm the block, and it does not disturb a pending window that has not yet opened. A prefix code on the bus with `sync_i` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one rising edge per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | High during an opcode fetch cycle |
| opcode_i | input | 8 | Byte on the data bus during the fetch |
| far_bank_i | input | 8 | Far bank value from the bank register |
| far_stb_o | output | 1 | Far access window active this cycle |
| upper_addr_o | output | 8 | Upper address bits [23:16] |

## Verification
Each of the four delay codes is issued in both the short form and the long form, with a distinct bank value for each, so that an error of one cycle in the delay or the width shows up as an early, late or missing strobe. In one pattern an opcode fetch lands inside a long window, which separates gating from cancellation. In another, a second prefix is issued whose window opens before the first one would have, so a reload can be told apart from two overlapping windows. Further patterns cover non-prefix fetches, prefix bytes with sync low, the bank value changing during a window, and reset arriving while a prefix is pending.

// File: rtl/far_pkg.sv
package far_pkg;
  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic             valid;
    logic             long_mode;
    logic [SEL_W-1:0] sel;
  } prefix_cmd_t;
endpackage

// File: rtl/far_rst_sync.sv
module far_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/far_prefix_decode.sv
module far_prefix_decode
  import far_pkg::*;
#(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned TAG_W = 5,
  parameter logic [TAG_W-1:0] TAG = 5'b10110
) (
  input  logic            sync_i,
  input  logic [OP_W-1:0] opcode_i,
  output prefix_cmd_t     cmd_o
);
  localparam int unsigned LONG_BIT = SEL_W;

  logic tag_hit;

  always_comb begin
    tag_hit         = (opcode_i[OP_W-1 -: TAG_W] == TAG);
    cmd_o.valid     = sync_i && tag_hit;
    cmd_o.long_mode = opcode_i[LONG_BIT];
    cmd_o.sel       = opcode_i[SEL_W-1:0];
  end

  initial begin
    if (OP_W != TAG_W + SEL_W + 1)
      $error("far_prefix_decode: opcode width does not fit tag, flag and select");
  end
endmodule

// File: rtl/far_delay_line.sv
module far_delay_line
  import far_pkg::*;
#(
  parameter int unsigned MIN_D    = 2,
  parameter int unsigned LONG_LEN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  prefix_cmd_t cmd_i,
  input  logic        cut_i,
  output logic        fire_o
);
  localparam int unsigned N_CODES = 1 << SEL_W;
  localparam int unsigned MAX_D   = MIN_D + N_CODES - 1;
  localparam int unsigned SR_W    = MAX_D + LONG_LEN;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;
  logic [SR_W-1:0] pattern;
  logic [SR_W-1:0] pat_tab [N_CODES*2];

  // one pattern per (length, delay) pair, built by generate
  for (genvar g = 0; g < N_CODES * 2; g++) begin : g_pat
    localparam int unsigned DLY = MIN_D + (g % N_CODES);
    localparam int unsigned LEN = (g >= N_CODES) ? LONG_LEN : 1;
    for (genvar b = 0; b < SR_W; b++) begin : g_bit
      assign pat_tab[g][b] = (b >= DLY) && (b < DLY + LEN);
    end
  end

  always_comb begin
    pattern = pat_tab[{cmd_i.long_mode, cmd_i.sel}];
  end

  // next state: a load wins; a fetch inside an open window drops the rest
  always_comb begin
    if (cmd_i.valid)              sr_d = pattern;
    else if (cut_i && sr_q[0])    sr_d = '0;
    else                          sr_d = sr_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign fire_o = sr_q[0];

  // R8: with nothing loaded, an empty line stays empty
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_i.valid && sr_q == '0) |=> (sr_q == '0));

  // R2: a load leaves a marker of one or LONG_LEN bits
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.valid |=> ($countones(sr_q) == 1 || $countones(sr_q) == LONG_LEN));

  // R6: a fetch during an open window leaves nothing pending
  p_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_i && fire_o && !cmd_i.valid) |=> (sr_q == '0));

  // R3: a short marker gives a single-cycle strobe
  p_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.valid && !cmd_i.long_mode) |=> ($countones(sr_q) == 1));
endmodule

// File: rtl/far_addr_mux.sv
module far_addr_mux #(
  parameter int unsigned UA_W = 8
) (
  input  logic            fire_i,
  input  logic            sync_i,
  input  logic [UA_W-1:0] bank_i,
  output logic            stb_o,
  output logic [UA_W-1:0] addr_o
);
  always_comb begin
    stb_o  = fire_i && !sync_i;
    addr_o = stb_o ? bank_i : '0;
  end
endmodule

// File: rtl/far_window.sv
module far_window
  import far_pkg::*;
#(
  parameter int unsigned OP_W     = 8,
  parameter int unsigned UA_W     = 8,
  parameter int unsigned MIN_D    = 2,
  parameter int unsigned LONG_LEN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic [UA_W-1:0] far_bank_i,
  output logic            far_stb_o,
  output logic [UA_W-1:0] upper_addr_o
);
  logic        rst_q_n;
  prefix_cmd_t cmd;
  logic        fire;

  far_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  far_prefix_decode #(.OP_W(OP_W), .TAG_W(OP_W - SEL_W - 1)) u_dec (
    .sync_i   (sync_i),
    .opcode_i (opcode_i),
    .cmd_o    (cmd)
  );

  far_delay_line #(.MIN_D(MIN_D), .LONG_LEN(LONG_LEN)) u_dly (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .cmd_i  (cmd),
    .cut_i  (sync_i),
    .fire_o (fire)
  );

  far_addr_mux #(.UA_W(UA_W)) u_mux (
    .fire_i (fire),
    .sync_i (sync_i),
    .bank_i (far_bank_i),
    .stb_o  (far_stb_o),
    .addr_o (upper_addr_o)
  );

  // R6: fetch cycles always use the normal mapping
  p_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    sync_i |-> !far_stb_o);

  // R5: upper address follows the bank only inside the window
  p_far_addr_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    far_stb_o |-> (upper_addr_o == far_bank_i));

  p_near_addr_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !far_stb_o |-> (upper_addr_o == '0));

  // R1: a cycle after internal reset release starts with no strobe
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rst_q_n) |-> !far_stb_o);
endmodule

// File: tb/far_window_tb.sv
`timescale 1ns/1ps
module far_window_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_i = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic [7:0] far_bank_i = 8'h00;
  logic       far_stb_o;
  logic [7:0] upper_addr_o;

  always #2.5 clk = ~clk;

  far_window u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .opcode_i     (opcode_i),
    .far_bank_i   (far_bank_i),
    .far_stb_o    (far_stb_o),
    .upper_addr_o (upper_addr_o)
  );

  typedef struct {
    logic       stb;
    logic [7:0] addr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   win_lo = -1;
  int   win_hi = -2;
  bit   done = 1'b0;

  // driver: one bus cycle, expected result pushed to the scoreboard
  task automatic step(input logic s, input logic [7:0] op,
                      input logic [7:0] bank, input string tag);
    exp_t e;
    bit   in_win;
    int   d;
    @(negedge clk);
    sync_i = s; opcode_i = op; far_bank_i = bank;
    cyc++;
    in_win = (cyc >= win_lo) && (cyc <= win_hi);
    e.stb  = in_win && !s;
    e.addr = e.stb ? bank : 8'h00;
    e.tag  = tag;
    q.push_back(e);
    if (s && in_win) begin win_lo = -1; win_hi = -2; end
    if (s && op[7:3] == 5'b10110) begin
      d      = 2 + int'(op[1:0]);
      win_lo = cyc + 1 + d;
      win_hi = win_lo + (op[2] ? 2 : 0);
    end
  endtask

  task automatic idle(input int n, input logic [7:0] bank, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'hEA, bank, tag);
  endtask

  task automatic do_reset(input int n, input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    win_lo = -1; win_hi = -2;
    idle(n, 8'h77, tag);
    rst_n = 1'b1;
    idle(4, 8'h77, tag);
  endtask

  // monitor: pop and compare away from the clock edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++;
        if (far_stb_o !== e.stb || upper_addr_o !== e.addr) begin
          n_bad++;
          $display("FAIL %s: stb=%0b addr=%h expected stb=%0b addr=%h",
                   e.tag, far_stb_o, upper_addr_o, e.stb, e.addr);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: state during and after reset
    idle(3, 8'h77, "R1");
    rst_n = 1'b1;
    idle(4, 8'h77, "R1");

    // R2/R3: four delays, short window
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 8'hB0 | 8'(s), 8'h10 + 8'(s), "R3");
      idle(1, 8'h10 + 8'(s), "R3");
      step(1'b1, 8'hA9, 8'h10 + 8'(s), "R3");
      idle(8, 8'h10 + 8'(s), "R3");
    end

    // R2/R4: four delays, long window
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 8'hB4 | 8'(s), 8'hC0 + 8'(s), "R4");
      idle(1, 8'hC0 + 8'(s), "R4");
      step(1'b1, 8'hA9, 8'hC0 + 8'(s), "R4");
      idle(10, 8'hC0 + 8'(s), "R4");
    end

    // R5: bank value changes inside a long window
    step(1'b1, 8'hB4, 8'h01, "R5");
    idle(1, 8'h02, "R5");
    step(1'b1, 8'hA9, 8'h03, "R5");
    idle(1, 8'h5A, "R5");
    idle(1, 8'hA5, "R5");
    idle(1, 8'hFF, "R5");
    idle(4, 8'h3C, "R5");

    // R6: fetch lands in the middle of a long window
    step(1'b1, 8'hB4, 8'h66, "R6");
    idle(1, 8'h66, "R6");
    step(1'b1, 8'hA9, 8'h66, "R6");
    idle(1, 8'h66, "R6");
    step(1'b1, 8'hA9, 8'h66, "R6");
    idle(6, 8'h66, "R6");

    // R7: second prefix replaces the first
    step(1'b1, 8'hB3, 8'h99, "R7");
    idle(1, 8'h99, "R7");
    step(1'b1, 8'hB0, 8'h99, "R7");
    idle(9, 8'h99, "R7");

    // R8: non-prefix fetches and prefix bytes without sync
    step(1'b1, 8'hB8, 8'h44, "R8");
    step(1'b1, 8'hAF, 8'h44, "R8");
    step(1'b0, 8'hB1, 8'h44, "R8");
    step(1'b0, 8'hB6, 8'h44, "R8");
    idle(10, 8'h44, "R8");

    // R8: a non-prefix fetch before the window opens leaves it intact
    step(1'b1, 8'hB2, 8'h21, "R8");
    idle(1, 8'h21, "R8");
    step(1'b1, 8'hA9, 8'h21, "R8");
    step(1'b1, 8'hAD, 8'h21, "R8");
    idle(8, 8'h21, "R8");

    // R1: reset while a prefix is pending
    step(1'b1, 8'hB7, 8'h88, "R1");
    idle(1, 8'h88, "R1");
    do_reset(2, "R1");
    idle(10, 8'h88, "R1");

    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule